// File: doc/BRIEF.md
# Sigma-Delta Bitstream Decimator (64:1)

This block turns the single-bit output of an oversampling sigma-delta modulator into a stream of 16-bit two's-complement samples. The input runs at 64 times the output rate. Each accepted bit is mapped to +1 (bit high) or -1 (bit low). A fourth-order cascaded integrator-comb (CIC) stage then low-pass filters the stream and drops the rate by 16. An 8-tap symmetric FIR stage smooths the result and drops the rate by a further 4. The FIR result is scaled to 16 bits and clamped. A one-cycle strobe marks each new sample.

All timing is counted in accepted input bits, so the passband edge, which sits near 0.439 of the output rate, follows the bit rate. When the input is held low on `bit_vld`, the filter freezes. If the scaled FIR result falls outside the 16-bit range, the output is clamped to the nearest extreme and a one-cycle overflow pulse is raised together with that sample. After reset, the first three FIR results are suppressed while the pipeline fills.

Top module: `sdm_decim64`

## Requirements
- R1: An accepted input bit of 1 enters the filter as +1 and a bit of 0 enters as -1, so the DC gain is symmetric about zero.
- R2: `sample_vld` is a single-cycle pulse, and consecutive pulses are separated by exactly 64 accepted input bits.
- R3: After a synchronous reset, with a bit accepted on every cycle, `sample_vld` stays low until it first rises three clock edges after the edge that accepts the 256th input bit. The first three FIR results are suppressed.
- R4: A constant all-ones input yields `sample_out` = 0x7FFF with `ovf_pulse` high on every valid sample, because the scaled result would be +32768.
- R5: A constant all-zeros input yields `sample_out` = 0x8000 with `ovf_pulse` low, because -32768 is representable.
- R6: An alternating 1/0 input yields `sample_out` = 0x0000 on every valid sample.
- R7: A repeating input of three ones then one zero yields 0x4000. A repeating input of one one then three zeros yields 0xC000.
- R8: When `bit_vld` is low, no bit is accepted and the filter state holds, so inserting idle cycles does not change any output value or the 64-bit spacing.
- R9: While `rst` is high, `sample_out` is 0, and `sample_vld` and `ovf_pulse` are low.
- R10: `ovf_pulse` is high only in a cycle where `sample_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Marks the cycle in which `bit_in` is accepted |
| bit_in | input | 1 | Modulator output bit |
| sample_out | output | 16 | Decimated two's-complement sample |
| sample_vld | output | 1 | One-cycle strobe for `sample_out` |
| ovf_pulse | output | 1 | One-cycle pulse: this sample was clamped |

## Verification
The bench builds the block with its default parameters: CIC order 4 with a ratio of 16, 8 FIR taps decimating by 4, an output shift of 6, and truncating scaling. With these values a full-scale positive input lands exactly one count above the 16-bit maximum, so clamping and the overflow pulse can be reached. A full-scale negative input lands exactly on the minimum, which separates the two clamp directions. The duty-cycle patterns give exact quarter-scale outputs, and an idle-cycle run shows that timing follows accepted bits rather than clock cycles.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

   // Triangular symmetric FIR coefficient: 1,3,5,...,5,3,1
   function automatic int fir_coef(input int k, input int taps);
      int m;
      m = (k < taps - 1 - k) ? k : taps - 1 - k;
      return 2 * m + 1;
   endfunction

   function automatic int fir_coef_sum(input int taps);
      int s;
      s = 0;
      for (int k = 0; k < taps; k++) s += fir_coef(k, taps);
      return s;
   endfunction

endpackage

// File: rtl/sdd_cic.sv
module sdd_cic #(
   parameter int ORDER = 4,
   parameter int LOG2R = 4,
   parameter int W     = 2 + ORDER * LOG2R
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_vld,
   input  logic                in_bit,
   output logic                out_vld,
   output logic signed [W-1:0] out_data
);

   generate
      if (ORDER < 1 || LOG2R < 1) begin : g_bad_cfg
         $error("sdd_cic: ORDER and LOG2R must be at least 1");
      end
      if (W < 2 + ORDER * LOG2R) begin : g_bad_w
         $error("sdd_cic: W too narrow for benign wraparound");
      end
   endgenerate

   logic signed [W-1:0] x;
   logic signed [W-1:0] integ [ORDER];
   logic signed [W-1:0] cdly  [ORDER];
   logic signed [W-1:0] cstg  [ORDER+1];
   logic [LOG2R-1:0]    phase;
   logic                strobe;

   // R1: bit 1 -> +1, bit 0 -> -1
   assign x      = in_bit ? W'(1) : '1;
   assign strobe = in_vld && (phase == '1);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < ORDER; i++) integ[i] <= '0;
         phase <= '0;
      end else if (in_vld) begin
         integ[0] <= integ[0] + x;
         for (int i = 1; i < ORDER; i++) integ[i] <= integ[i] + integ[i-1];
         phase <= phase + 1'b1;
      end
   end

   always_comb begin
      cstg[0] = integ[ORDER-1];
      for (int i = 0; i < ORDER; i++) cstg[i+1] = cstg[i] - cdly[i];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < ORDER; i++) cdly[i] <= '0;
         out_data <= '0;
         out_vld  <= 1'b0;
      end else begin
         out_vld <= strobe;
         if (strobe) begin
            for (int i = 0; i < ORDER; i++) cdly[i] <= cstg[i];
            out_data <= cstg[ORDER];
         end
      end
   end

   p_cic_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> $stable(integ[0]));

   p_cic_single_r2: assert property (@(posedge clk) disable iff (rst)
      out_vld |=> !out_vld);

endmodule

// File: rtl/sdd_fir.sv
module sdd_fir #(
   parameter int IN_W  = 18,
   parameter int TAPS  = 8,
   parameter int LOG2D = 2,
   parameter int ACC_W = IN_W + $clog2(sdd_pkg::fir_coef_sum(TAPS)) + 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_vld,
   input  logic signed [IN_W-1:0]  in_data,
   output logic                    acc_vld,
   output logic signed [ACC_W-1:0] acc
);

   generate
      if (TAPS < 2 || LOG2D < 1) begin : g_bad_cfg
         $error("sdd_fir: need at least 2 taps and LOG2D >= 1");
      end
   endgenerate

   logic signed [IN_W-1:0]  dl [TAPS];
   logic signed [ACC_W-1:0] sum;
   logic [LOG2D-1:0]        phase;
   logic                    go;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < TAPS; i++) dl[i] <= '0;
         phase <= '0;
         go    <= 1'b0;
      end else begin
         go <= in_vld && (phase == '1);
         if (in_vld) begin
            dl[0] <= in_data;
            for (int i = 1; i < TAPS; i++) dl[i] <= dl[i-1];
            phase <= phase + 1'b1;
         end
      end
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < TAPS; i++)
         sum += ACC_W'(dl[i]) * ACC_W'(sdd_pkg::fir_coef(i, TAPS));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc     <= '0;
         acc_vld <= 1'b0;
      end else begin
         acc_vld <= go;
         if (go) acc <= sum;
      end
   end

   p_fir_single_r2: assert property (@(posedge clk) disable iff (rst)
      acc_vld |=> !acc_vld);

endmodule

// File: rtl/sdd_sat.sv
module sdd_sat #(
   parameter int ACC_W = 24,
   parameter int OUT_W = 16,
   parameter int SHIFT = 6,
   parameter bit ROUND = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    pass,
   input  logic signed [ACC_W-1:0] acc,
   output logic [OUT_W-1:0]        data,
   output logic                    vld,
   output logic                    ovf
);

   generate
      if (ACC_W <= OUT_W + SHIFT) begin : g_bad_w
         $error("sdd_sat: ACC_W must exceed OUT_W + SHIFT");
      end
      if (ROUND && SHIFT < 1) begin : g_bad_rnd
         $error("sdd_sat: rounding needs SHIFT >= 1");
      end
   endgenerate

   localparam logic signed [ACC_W-1:0] MAXV =
      {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] MINV =
      {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
   localparam logic [OUT_W-1:0] MAXO = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] MINO = {1'b1, {(OUT_W-1){1'b0}}};

   logic signed [ACC_W-1:0] pre;
   logic signed [ACC_W-1:0] sh;
   logic                    hi, lo;

   generate
      if (ROUND) begin : g_round
         assign pre = acc + (ACC_W'(1) <<< (SHIFT - 1));
      end else begin : g_trunc
         assign pre = acc;
      end
   endgenerate

   assign sh = pre >>> SHIFT;
   assign hi = sh > MAXV;
   assign lo = sh < MINV;

   always_ff @(posedge clk) begin
      if (rst) begin
         data <= '0;
         vld  <= 1'b0;
         ovf  <= 1'b0;
      end else begin
         vld <= pass;
         ovf <= pass && (hi || lo);
         if (pass) data <= hi ? MAXO : (lo ? MINO : sh[OUT_W-1:0]);
      end
   end

   p_sat_dir_r4: assert property (@(posedge clk) disable iff (rst)
      (ovf && !data[OUT_W-1]) |-> (data == MAXO));

   p_sat_code_r5: assert property (@(posedge clk) disable iff (rst)
      ovf |-> (data == MAXO || data == MINO));

endmodule

// File: rtl/sdm_decim64.sv
module sdm_decim64 #(
   parameter int CIC_ORDER = 4,
   parameter int CIC_LOG2R = 4,
   parameter int FIR_TAPS  = 8,
   parameter int FIR_LOG2D = 2,
   parameter int OUT_W     = 16,
   parameter int OUT_SHIFT = 6,
   parameter bit OUT_ROUND = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_vld,
   input  logic             bit_in,
   output logic [OUT_W-1:0] sample_out,
   output logic             sample_vld,
   output logic             ovf_pulse
);

   localparam int CIC_W  = 2 + CIC_ORDER * CIC_LOG2R;
   localparam int ACC_W  = CIC_W + $clog2(sdd_pkg::fir_coef_sum(FIR_TAPS)) + 1;
   localparam int DEC2   = 1 << FIR_LOG2D;
   localparam int FILL   = (CIC_ORDER + FIR_TAPS + DEC2 - 1) / DEC2;
   localparam int FW     = $clog2(FILL + 1);
   localparam logic [FW-1:0] FILL_V = FW'(FILL);
   localparam int TOTAL  = 1 << (CIC_LOG2R + FIR_LOG2D);

   generate
      if (CIC_LOG2R + FIR_LOG2D != 6) begin : g_bad_ratio
         $error("sdm_decim64: overall decimation must be 64");
      end
   endgenerate

   logic                    cic_vld;
   logic signed [CIC_W-1:0] cic_data;
   logic                    acc_vld;
   logic signed [ACC_W-1:0] acc;
   logic [FW-1:0]           fill_cnt;
   logic                    pass;

   sdd_cic #(.ORDER(CIC_ORDER), .LOG2R(CIC_LOG2R), .W(CIC_W)) u_cic (
      .clk(clk), .rst(rst), .in_vld(bit_vld), .in_bit(bit_in),
      .out_vld(cic_vld), .out_data(cic_data)
   );

   sdd_fir #(.IN_W(CIC_W), .TAPS(FIR_TAPS), .LOG2D(FIR_LOG2D), .ACC_W(ACC_W)) u_fir (
      .clk(clk), .rst(rst), .in_vld(cic_vld), .in_data(cic_data),
      .acc_vld(acc_vld), .acc(acc)
   );

   // R3: suppress the first FILL results after reset
   always_ff @(posedge clk) begin
      if (rst) fill_cnt <= '0;
      else if (acc_vld && fill_cnt != FILL_V) fill_cnt <= fill_cnt + 1'b1;
   end
   assign pass = acc_vld && (fill_cnt == FILL_V);

   sdd_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(OUT_SHIFT), .ROUND(OUT_ROUND)) u_sat (
      .clk(clk), .rst(rst), .pass(pass), .acc(acc),
      .data(sample_out), .vld(sample_vld), .ovf(ovf_pulse)
   );

   // Independent count of accepted bits for the fill check
   localparam int SW = $clog2(TOTAL * (FILL + 1) + 1);
   localparam logic [SW-1:0] SEEN_MAX = SW'(TOTAL * (FILL + 1));
   logic [SW-1:0] seen;
   always_ff @(posedge clk) begin
      if (rst) seen <= '0;
      else if (bit_vld && seen != SEEN_MAX) seen <= seen + 1'b1;
   end

   p_fill_r3: assert property (@(posedge clk) disable iff (rst)
      sample_vld |-> (seen == SEEN_MAX));

   p_vld_single_r2: assert property (@(posedge clk) disable iff (rst)
      sample_vld |=> !sample_vld);

   p_ovf_vld_r10: assert property (@(posedge clk) disable iff (rst)
      ovf_pulse |-> sample_vld);

   p_reset_r9: assert property (@(posedge clk)
      $past(rst) |-> (!sample_vld && !ovf_pulse && sample_out == '0));

endmodule

// File: tb/sdm_decim64_tb.sv
module sdm_decim64_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bit_vld = 1'b0;
   logic        bit_in = 1'b0;
   logic [15:0] sample_out;
   logic        sample_vld;
   logic        ovf_pulse;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   sdm_decim64 u_dut (
      .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
      .sample_out(sample_out), .sample_vld(sample_vld), .ovf_pulse(ovf_pulse)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic bit pat_bit(input int kind, input int idx);
      case (kind)
         0: return 1'b1;                 // all ones
         1: return 1'b0;                 // all zeros
         2: return (idx % 2) == 0;       // alternating
         3: return (idx % 4) != 3;       // 75 % ones
         default: return (idx % 4) == 0; // 25 % ones
      endcase
   endfunction

   // R9: reset state checked while rst is held
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      bit_vld = 1'b0;
      repeat (3) @(negedge clk);
      check(sample_out == 16'h0, "R9 data", sample_out, 0);
      check(sample_vld == 1'b0, "R9 vld", sample_vld, 0);
      check(ovf_pulse == 1'b0, "R9 ovf", ovf_pulse, 0);
      rst = 1'b0;
   endtask

   task automatic run_case(input int kind, input bit gap, input logic [15:0] exp_d,
                           input bit exp_o, input string req);
      int acc = 0;
      int nv = 0;
      int last = -1;
      int cyc = 0;
      do_reset();
      while (nv < 6 && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (sample_vld) begin
            nv++;
            if (nv == 1 && !gap) check(acc == 259, "R3 first valid", acc, 259);
            if (last >= 0) check(acc - last == 64, gap ? "R8 spacing" : "R2 spacing", acc - last, 64);
            last = acc;
            check(sample_out == exp_d, req, sample_out, exp_d);
            check(ovf_pulse == exp_o, {req, " ovf"}, ovf_pulse, exp_o);
         end else if (ovf_pulse) begin
            check(1'b0, "R10 stray ovf", 1, 0);
         end
         if (gap && (cyc % 2) == 0) begin
            bit_vld = 1'b0;
            bit_in  = ~bit_in;
         end else begin
            bit_vld = 1'b1;
            bit_in  = pat_bit(kind, acc);
            acc++;
         end
      end
      bit_vld = 1'b0;
      check(nv == 6, {req, " sample count"}, nv, 6);
   endtask

   task automatic t_ones();  run_case(0, 1'b0, 16'h7FFF, 1'b1, "R4 ones");       endtask
   task automatic t_zeros(); run_case(1, 1'b0, 16'h8000, 1'b0, "R5 R1 zeros");   endtask
   task automatic t_alt();   run_case(2, 1'b0, 16'h0000, 1'b0, "R6 alternate");  endtask
   task automatic t_d75();   run_case(3, 1'b0, 16'h4000, 1'b0, "R7 R1 duty75");  endtask
   task automatic t_d25();   run_case(4, 1'b0, 16'hC000, 1'b0, "R7 duty25");     endtask
   task automatic t_gap();   run_case(3, 1'b1, 16'h4000, 1'b0, "R8 idle gaps");  endtask

   initial begin
      t_ones();
      t_zeros();
      t_alt();
      t_d75();
      t_d25();
      t_gap();
      t_ones();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule